// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Controller

This block watches a bank of independent input lines and turns selected transitions on them into requests for the rest of the chip. Every line has its own edge detector. Software chooses per line whether a rising transition, a falling transition or both count as a trigger. A qualified trigger can latch a sticky interrupt request, emit a single-clock event pulse, or do both, and each of the two paths has its own mask.

Software reaches the block through a 32-bit word-wide bus port that uses the familiar select/enable/write handshake with zero wait states. Six word registers hold the interrupt mask, the event mask, the rising and falling selections, a software trigger and the pending latches. A line can also be fired from software, without any activity on its input. Each line input is resynchronised before its edge is examined, so the inputs may be asynchronous to the block clock.

Top module: `edge_irq_hub`

## Requirements
- R1: After reset all six registers read zero, and `irq_out` and `evt_out` are zero.
- R2: Word registers sit at byte offsets 0x00 interrupt mask, 0x04 event mask, 0x08 rising select, 0x0C falling select, 0x10 software trigger and 0x14 pending. Bit n of each register belongs to line n. Read bits 31:24 are always zero, and a read of any other word offset returns zero.
- R3: A line whose rising-select bit is 1 triggers on a 0-to-1 change of its synchronised input. A line whose falling-select bit is 1 triggers on a 1-to-0 change. With both bits set, either change triggers. With neither bit set, the line never triggers from hardware.
- R4: A trigger on a line whose interrupt-mask bit is 1 sets its pending bit. `irq_out[n]` equals pending bit n AND interrupt-mask bit n. A line whose interrupt mask is 0 never gets its pending bit set.
- R5: Writing 1 to a bit of the pending register clears that bit. Writing 0 leaves the bit unchanged.
- R6: A trigger on a line whose event-mask bit is 1 drives `evt_out[n]` high for exactly one clock. The event path never sets a pending bit.
- R7: Writing 1 to a software trigger bit that currently reads 0 counts as a trigger on that line, for both the interrupt path and the event path. Writing 1 to a bit that already reads 1 produces no trigger.
- R8: A software trigger bit returns to 0 when a write of 1 is made to the same bit of the pending register.
- R9: A hardware edge that is detected in the same clock as a bus write to the rising-select or falling-select register is discarded.
- R10: If a hardware trigger and a write-1 clear of the same pending bit fall in the same clock, the pending bit ends set.
- R11: A line input passes through a two-flop synchroniser. A change on `line_in` appears on `irq_out` and `evt_out` after the third rising clock edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| line_in | input | 24 | Asynchronous line inputs |
| irq_out | output | 24 | Per-line interrupt request |
| evt_out | output | 24 | Per-line single-clock event pulse |

## Verification
The bench builds the block with its default parameters: 24 lines, a 32-bit data word, an 8-bit address and two synchroniser stages. These values put the eight reserved upper read bits and the unmapped word offsets 0x18 and 0x1C within reach of the bench. They also fix the input-to-output latency at exactly three edges. The bench therefore times the two collision cases to the cycle: a clear of the pending bit against a fresh edge, and a select-register write against a fresh edge. A vector table drives all-line patterns that mix rising, falling and both-edge selection with interleaved interrupt and event masks.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
   // word index of each register (byte offset / 4)
   typedef enum logic [2:0] {
      RI_IMASK = 3'd0,
      RI_EMASK = 3'd1,
      RI_RISE  = 3'd2,
      RI_FALL  = 3'd3,
      RI_SWT   = 3'd4,
      RI_PEND  = 3'd5
   } reg_idx_e;
   localparam int IDX_LSB = 2;
   localparam int IDX_MSB = 4;
endpackage

// File: rtl/eirq_line_sync.sv
module eirq_line_sync #(
   parameter int NUM_LINES   = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_in,
   output logic [NUM_LINES-1:0] rise,
   output logic [NUM_LINES-1:0] fall
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("eirq_line_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_LINES-1:0] synced;
   logic [NUM_LINES-1:0] prev_q;

   generate
      for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], line_in[g]};
         end
         assign synced[g] = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= synced;
   end

   assign rise = synced & ~prev_q;
   assign fall = ~synced & prev_q;

   // R3: a reported edge must match a change of the registered level
   edge_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |(rise | fall) |=> ((prev_q & $past(rise)) == $past(rise)) &&
                         ((~prev_q & $past(fall)) == $past(fall)));
endmodule

// File: rtl/eirq_regfile.sv
module eirq_regfile
   import edge_irq_pkg::*;
#(
   parameter int NUM_LINES = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  reg_idx_e             idx,
   input  logic [NUM_LINES-1:0] wdata,
   input  logic [NUM_LINES-1:0] hw_trig,
   output logic [NUM_LINES-1:0] imask,
   output logic [NUM_LINES-1:0] emask,
   output logic [NUM_LINES-1:0] rsel,
   output logic [NUM_LINES-1:0] fsel,
   output logic [NUM_LINES-1:0] swtrig,
   output logic [NUM_LINES-1:0] pend,
   output logic [NUM_LINES-1:0] trig
);
   logic [NUM_LINES-1:0] sw_fire;
   logic [NUM_LINES-1:0] clr_vec;

   assign sw_fire = (wr_en && idx == RI_SWT)  ? (wdata & ~swtrig) : '0;
   assign clr_vec = (wr_en && idx == RI_PEND) ? wdata : '0;
   assign trig    = hw_trig | sw_fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imask  <= '0;
         emask  <= '0;
         rsel   <= '0;
         fsel   <= '0;
         swtrig <= '0;
         pend   <= '0;
      end else begin
         if (wr_en && idx == RI_IMASK) imask <= wdata;
         if (wr_en && idx == RI_EMASK) emask <= wdata;
         if (wr_en && idx == RI_RISE)  rsel  <= wdata;
         if (wr_en && idx == RI_FALL)  fsel  <= wdata;
         if (wr_en && idx == RI_SWT) swtrig <= wdata;
         else                        swtrig <= swtrig & ~clr_vec;
         // new trigger wins over a clear in the same cycle
         pend <= (pend & ~clr_vec) | (trig & imask);
      end
   end

   // R4
   pend_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 (pend & ~$past(pend) & ~$past(imask)) == '0);

   // R5
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 ($past(pend) & ~pend & ~$past(clr_vec)) == '0);

   // R8
   sw_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 (swtrig & $past(clr_vec)) == '0);
endmodule

// File: rtl/edge_irq_hub.sv
module edge_irq_hub
   import edge_irq_pkg::*;
#(
   parameter int NUM_LINES   = 24,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 psel,
   input  logic                 penable,
   input  logic                 pwrite,
   input  logic [ADDR_W-1:0]    paddr,
   input  logic [DATA_W-1:0]    pwdata,
   output logic [DATA_W-1:0]    prdata,
   input  logic [NUM_LINES-1:0] line_in,
   output logic [NUM_LINES-1:0] irq_out,
   output logic [NUM_LINES-1:0] evt_out
);
   localparam int PAD_W = DATA_W - NUM_LINES;

   generate
      if (NUM_LINES < 1 || NUM_LINES >= DATA_W) begin : g_bad_lines
         $error("edge_irq_hub: NUM_LINES must be in 1..DATA_W-1");
      end
      if (ADDR_W <= IDX_MSB + 1) begin : g_bad_addr
         $error("edge_irq_hub: ADDR_W too small for the register window");
      end
   endgenerate

   logic                 wr_acc;
   logic                 win_hit;
   reg_idx_e             idx;
   logic                 sel_wr;
   logic [NUM_LINES-1:0] rise, fall, hw_trig, trig;
   logic [NUM_LINES-1:0] imask, emask, rsel, fsel, swtrig, pend;
   logic [NUM_LINES-1:0] rd_vec;
   logic [NUM_LINES-1:0] evt_q;
   logic                 unused_bits;

   assign idx     = reg_idx_e'(paddr[IDX_MSB:IDX_LSB]);
   assign win_hit = (paddr[ADDR_W-1:IDX_MSB+1] == '0);
   assign wr_acc  = psel & penable & pwrite & win_hit;
   assign sel_wr  = wr_acc & (idx == RI_RISE || idx == RI_FALL);
   assign unused_bits = ^{paddr[IDX_LSB-1:0], pwdata[DATA_W-1:NUM_LINES]};

   eirq_line_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .rise(rise), .fall(fall));

   // edges landing on a select-register write are dropped
   assign hw_trig = ((rise & rsel) | (fall & fsel)) & {NUM_LINES{~sel_wr}};

   eirq_regfile #(.NUM_LINES(NUM_LINES)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .idx(idx),
      .wdata(pwdata[NUM_LINES-1:0]), .hw_trig(hw_trig),
      .imask(imask), .emask(emask), .rsel(rsel), .fsel(fsel),
      .swtrig(swtrig), .pend(pend), .trig(trig));

   always_ff @(posedge clk) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= trig & emask;
   end

   assign evt_out = evt_q;
   assign irq_out = pend & imask;

   always_comb begin
      rd_vec = '0;
      if (win_hit) begin
         case (idx)
            RI_IMASK: rd_vec = imask;
            RI_EMASK: rd_vec = emask;
            RI_RISE:  rd_vec = rsel;
            RI_FALL:  rd_vec = fsel;
            RI_SWT:   rd_vec = swtrig;
            RI_PEND:  rd_vec = pend;
            default:  rd_vec = '0;
         endcase
      end
   end
   assign prdata = {{PAD_W{1'b0}}, rd_vec};

   // R6
   evt_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 (evt_out & ~$past(emask)) == '0);

   // R9
   sel_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (evt_out == '0) && ((pend & ~$past(pend)) == '0));

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psel |-> prdata[DATA_W-1:NUM_LINES] == '0);
endmodule

// File: tb/sim_edge_irq_hub.sv
module sim_edge_irq_hub;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic [23:0] line_in = '0;
   logic [23:0] irq_out, evt_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   edge_irq_hub u0 (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .line_in(line_in), .irq_out(irq_out), .evt_out(evt_out));

   // {imask, emask, rise_sel, fall_sel, line_before, line_after}
   localparam logic [143:0] VECS [6] = '{
      {24'hFFFFFF, 24'h000000, 24'hFFFFFF, 24'h000000, 24'h000000, 24'h00F00F},
      {24'h000000, 24'hFFFFFF, 24'h000000, 24'hFFFFFF, 24'hFFFFFF, 24'h0F0F0F},
      {24'hAAAAAA, 24'h555555, 24'hFFFFFF, 24'hFFFFFF, 24'h00FF00, 24'hFF00FF},
      {24'hFFFFFF, 24'hFFFFFF, 24'h000000, 24'h000000, 24'h000000, 24'hFFFFFF},
      {24'hFFFFFF, 24'hFFFFFF, 24'h123456, 24'h000000, 24'h000000, 24'hFFFFFF},
      {24'h800000, 24'h000001, 24'h000000, 24'h800001, 24'hFFFFFF, 24'h000000}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // called on a negedge; the write lands on the second posedge, returns on the next negedge
   task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(posedge clk); @(negedge clk); penable = 1'b1;
      @(posedge clk); @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(posedge clk); @(negedge clk); penable = 1'b1;
      #1 d = prdata;
      @(posedge clk); @(negedge clk); psel = 1'b0; penable = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      logic [23:0] im, em, rs, fs, pre, post, tr;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq_out", {8'h0, irq_out}, 32'h0);
      chk("R1 evt_out", {8'h0, evt_out}, 32'h0);
      for (int r = 0; r < 6; r++) begin
         apb_read(8'(r * 4), rd);
         chk("R1 reg reset", rd, 32'h0);
      end

      // R2 reserved bits and unmapped offsets
      apb_write(8'h00, 32'hFFFF_FFFF);
      apb_read(8'h00, rd);  chk("R2 imask upper zero", rd, 32'h00FF_FFFF);
      apb_write(8'h0C, 32'h0000_5A5A);
      apb_read(8'h0C, rd);  chk("R2 falling select offset", rd, 32'h0000_5A5A);
      apb_read(8'h18, rd);  chk("R2 unmapped 0x18", rd, 32'h0);
      apb_read(8'h1C, rd);  chk("R2 unmapped 0x1C", rd, 32'h0);

      // vector table: R3 R4 R6 R11
      for (int v = 0; v < 6; v++) begin
         {im, em, rs, fs, pre, post} = VECS[v];
         line_in = pre;
         repeat (5) @(negedge clk);
         apb_write(8'h00, {8'h0, im});
         apb_write(8'h04, {8'h0, em});
         apb_write(8'h08, {8'h0, rs});
         apb_write(8'h0C, {8'h0, fs});
         apb_write(8'h14, 32'h00FF_FFFF);
         tr = ((post & ~pre) & rs) | ((pre & ~post) & fs);
         line_in = post;
         @(posedge clk); @(posedge clk); @(negedge clk);
         chk("R11 no irq before third edge", {8'h0, irq_out}, 32'h0);
         chk("R11 no evt before third edge", {8'h0, evt_out}, 32'h0);
         @(negedge clk);
         chk("R3 R4 irq_out", {8'h0, irq_out}, {8'h0, tr & im});
         chk("R3 R6 evt_out", {8'h0, evt_out}, {8'h0, tr & em});
         @(negedge clk);
         chk("R6 evt one clock", {8'h0, evt_out}, 32'h0);
         apb_read(8'h14, rd);
         chk("R4 R6 pending", rd, {8'h0, tr & im});
      end

      // clean state
      line_in = '0;
      repeat (5) @(negedge clk);
      apb_write(8'h08, 32'h0);
      apb_write(8'h0C, 32'h0);
      apb_write(8'h14, 32'h00FF_FFFF);

      // R7 software trigger
      apb_write(8'h00, 32'h0000_0020);
      apb_write(8'h04, 32'h0000_0020);
      apb_write(8'h10, 32'h0000_0020);
      chk("R7 sw evt", {8'h0, evt_out}, 32'h0000_0020);
      chk("R7 sw irq", {8'h0, irq_out}, 32'h0000_0020);
      apb_write(8'h10, 32'h0000_0020);
      chk("R7 rewrite of set bit no evt", {8'h0, evt_out}, 32'h0);
      // R5 write of 0 keeps pending
      apb_write(8'h14, 32'h0000_0000);
      apb_read(8'h14, rd);  chk("R5 write zero keeps pending", rd, 32'h0000_0020);
      // R8 self clear
      apb_write(8'h14, 32'h0000_0020);
      apb_read(8'h10, rd);  chk("R8 sw bit self clears", rd, 32'h0);
      apb_read(8'h14, rd);  chk("R5 write one clears pending", rd, 32'h0);
      chk("R5 irq dropped", {8'h0, irq_out}, 32'h0);
      // R7 software trigger with interrupt masked
      apb_write(8'h00, 32'h0);
      apb_write(8'h04, 32'h0000_0080);
      apb_write(8'h10, 32'h0000_0080);
      chk("R7 sw evt masked irq", {8'h0, evt_out}, 32'h0000_0080);
      apb_read(8'h14, rd);  chk("R7 masked sw no pending", rd, 32'h0);

      // R9 edge coinciding with rising-select write
      apb_write(8'h04, 32'h0);
      apb_write(8'h00, 32'h0000_0002);
      apb_write(8'h08, 32'h0000_0002);
      line_in = 24'h000002;
      @(posedge clk); @(negedge clk);
      apb_write(8'h08, 32'h0000_0002);
      @(negedge clk);
      apb_read(8'h14, rd);  chk("R9 edge on select write dropped", rd, 32'h0);
      chk("R9 irq quiet", {8'h0, irq_out}, 32'h0);

      // R10 set wins over clear
      line_in = 24'h000000;
      repeat (5) @(negedge clk);
      line_in = 24'h000002;
      repeat (4) @(negedge clk);
      apb_read(8'h14, rd);  chk("R3 pending after edge", rd, 32'h0000_0002);
      line_in = 24'h000000;
      repeat (5) @(negedge clk);
      line_in = 24'h000002;
      @(posedge clk); @(negedge clk);
      apb_write(8'h14, 32'h0000_0002);
      apb_read(8'h14, rd);  chk("R10 set wins over clear", rd, 32'h0000_0002);
      chk("R10 irq held", {8'h0, irq_out}, 32'h0000_0002);
      apb_write(8'h14, 32'h0000_0002);
      apb_read(8'h14, rd);  chk("R5 later clear works", rd, 32'h0);

      finish_run();
   end
endmodule